// File: doc/BRIEF.md
# Configurable Multi-Input Logic Gate

This block is one reconfigurable logic element. It combines up to `LANES` one-bit data lines under a rule picked at run time: AND, OR or XOR, each optionally inverted into NAND, NOR or XNOR. A per-line participation mask picks which lines the rule sees. Lines outside the mask have no effect at all.

The result is purely combinational, with no clock and no storage. It drives a gate output and a separate "output high" indicator that always carries the same value. XOR is a true parity function over every participating line, not an "exactly one" test, so three lines give a full-adder sum bit. When the rule selection is not a single valid choice, the gate drives its output low and raises an error flag.

The gate is built for netlists whose fan-in and function change while running. One line with OR gives a buffer. One line with NOR gives an inverter.

Top module: `cfg_logic_gate`

## Requirements
- R1: `ruleSel` is one-hot with bit 0 selecting AND, bit 1 selecting OR and bit 2 selecting XOR. With AND selected and `invertEn` low, `gateOut` is 1 exactly when every line whose `joinMask` bit is set has `dataIn` high.
- R2: With OR selected and `invertEn` low, `gateOut` is 1 exactly when at least one participating line is high.
- R3: With XOR selected and `invertEn` low, `gateOut` is 1 exactly when an odd number of participating lines are high, for any number of participating lines.
- R4: With `invertEn` high and a valid selection, `gateOut` is the complement of the R1 to R3 result (NAND, NOR, XNOR). XNOR over zero high participating lines gives 1.
- R5: A line whose `joinMask` bit is clear never changes `gateOut`, whatever its `dataIn` value.
- R6: With `joinMask` all zero, the uninverted result is 1 for AND, 0 for OR and 0 for XOR. `invertEn` then complements it.
- R7: When `ruleSel` does not have exactly one bit set, `gateOut` is 0 and `cfgError` is 1 whatever `invertEn` is. Otherwise `cfgError` is 0.
- R8: `outHigh` equals `gateOut` for every input combination.
- R9: With exactly one participating line, OR passes that line through unchanged and NOR gives its complement.
- R10: The line count is the parameter `LANES`, default 8. Every width scales with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ruleSel | input | 3 | One-hot rule select: bit 0 AND, bit 1 OR, bit 2 XOR |
| invertEn | input | 1 | Complements the selected rule |
| joinMask | input | LANES | Set bit means the matching data line takes part |
| dataIn | input | LANES | One-bit data lines |
| gateOut | output | 1 | Gate result |
| outHigh | output | 1 | Indicator, high whenever the result is high |
| cfgError | output | 1 | Rule select is not one-hot |

## Verification
The bench aims at the empty mask. A design that reduced over raw data would give 0 for AND, and one that forgot the invert there would get XNOR of nothing wrong. It drives three and more high lines under XOR, which a design testing for "exactly one" would miss. It sets unmasked lines high under every rule, which exposes any leak of unmasked data into the AND, OR or parity terms. It also tries zero-hot and multi-hot selections with the invert flag set, where a design that applied the invert after forcing the output low would wrongly drive 1.

// File: rtl/cfg_gate_pkg.sv
package cfg_gate_pkg;
  localparam int RULE_W   = 3;
  localparam int RULE_AND = 0;
  localparam int RULE_OR  = 1;
  localparam int RULE_XOR = 2;

  // strobes from the rule decoder to the datapath
  typedef struct packed {
    logic useAnd;
    logic useOr;
    logic useXor;
    logic flip;
    logic fault;
  } gateStrobe_t;
endpackage

// File: rtl/cfg_gate_ctrl.sv
module cfg_gate_ctrl
  import cfg_gate_pkg::*;
(
  input  logic [RULE_W-1:0] ruleSel,
  input  logic              invertEn,
  output gateStrobe_t       strobe
);
  always_comb begin
    strobe = '0;
    strobe.flip = invertEn;
    unique case (ruleSel)
      3'b001:  strobe.useAnd = 1'b1;
      3'b010:  strobe.useOr  = 1'b1;
      3'b100:  strobe.useXor = 1'b1;
      default: strobe.fault  = 1'b1;
    endcase
  end

  // R7: at most one rule strobe, and the fault follows the select's bit count
  always_comb begin
    a_r7_single_rule: assert ($onehot0({strobe.useAnd, strobe.useOr, strobe.useXor}));
    a_r7_fault_count: assert (strobe.fault == ($countones(ruleSel) != 1));
  end
endmodule

// File: rtl/cfg_gate_datapath.sv
module cfg_gate_datapath
  import cfg_gate_pkg::*;
#(
  parameter int LANES = 8
) (
  input  gateStrobe_t      strobe,
  input  logic [LANES-1:0] joinMask,
  input  logic [LANES-1:0] dataIn,
  output logic             gateOut,
  output logic             outHigh
);
  logic [LANES-1:0] andTerm;
  logic [LANES-1:0] orTerm;
  logic allHigh, anyHigh, oddHigh, baseVal, result;

  // an unjoined lane looks like 1 to AND and 0 to OR/parity
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign andTerm[i] = dataIn[i] | ~joinMask[i];
    assign orTerm[i]  = dataIn[i] &  joinMask[i];
  end

  assign allHigh = &andTerm;
  assign anyHigh = |orTerm;
  assign oddHigh = ^orTerm;

  always_comb begin
    baseVal = 1'b0;
    if (strobe.useAnd)      baseVal = allHigh;
    else if (strobe.useOr)  baseVal = anyHigh;
    else if (strobe.useXor) baseVal = oddHigh;
    result = strobe.fault ? 1'b0 : (baseVal ^ strobe.flip);
  end

  assign gateOut = result;
  assign outHigh = result;

  always_comb begin
    // R7: a bad select never lets the output rise
    if (strobe.fault) a_r7_forced_low: assert (!gateOut);
    // R6: empty mask gives the rule's identity, then the invert
    if (joinMask == '0 && !strobe.fault)
      a_r6_empty_identity: assert (gateOut == (strobe.useAnd ^ strobe.flip));
    // R2: any joined high line makes plain OR high
    if (strobe.useOr && !strobe.flip && (dataIn & joinMask) != '0)
      a_r2_or_any: assert (gateOut);
    // R8: the indicator mirrors the output
    a_r8_indicator: assert (outHigh == gateOut);
  end
endmodule

// File: rtl/cfg_logic_gate.sv
module cfg_logic_gate
  import cfg_gate_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic [RULE_W-1:0] ruleSel,
  input  logic              invertEn,
  input  logic [LANES-1:0]  joinMask,
  input  logic [LANES-1:0]  dataIn,
  output logic              gateOut,
  output logic              outHigh,
  output logic              cfgError
);
  gateStrobe_t strobe;

  cfg_gate_ctrl u_ctrl (
    .ruleSel (ruleSel),
    .invertEn(invertEn),
    .strobe  (strobe)
  );

  cfg_gate_datapath #(.LANES(LANES)) u_dp (
    .strobe  (strobe),
    .joinMask(joinMask),
    .dataIn  (dataIn),
    .gateOut (gateOut),
    .outHigh (outHigh)
  );

  assign cfgError = strobe.fault;
endmodule

// File: tb/cfg_logic_gate_bench.sv
module cfg_logic_gate_bench;
  localparam int LANES = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [2:0]       ruleSel = '0;
  logic             invertEn = 1'b0;
  logic [LANES-1:0] joinMask = '0;
  logic [LANES-1:0] dataIn = '0;
  logic gateOut, outHigh, cfgError;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  cfg_logic_gate #(.LANES(LANES)) u_cfg_logic_gate (
    .ruleSel(ruleSel), .invertEn(invertEn), .joinMask(joinMask),
    .dataIn(dataIn), .gateOut(gateOut), .outHigh(outHigh), .cfgError(cfgError)
  );

  // behavioural model: count joined lines and joined high lines
  task automatic apply(input logic [2:0] r, input logic inv,
                       input logic [LANES-1:0] m, input logic [LANES-1:0] d,
                       input string tag);
    int joined = 0, highs = 0, picks = 0;
    logic expOut, expErr, base;
    @(posedge clk); #1;
    ruleSel = r; invertEn = inv; joinMask = m; dataIn = d;
    for (int i = 0; i < LANES; i++) begin
      if (m[i]) begin joined++; if (d[i]) highs++; end
    end
    for (int i = 0; i < 3; i++) if (r[i]) picks++;
    expErr = (picks != 1);
    if (r == 3'b001)      base = (highs == joined);
    else if (r == 3'b010) base = (highs > 0);
    else                  base = (highs % 2 == 1);
    expOut = expErr ? 1'b0 : (base ^ inv);
    @(negedge clk);
    checks++;
    if (gateOut !== expOut || outHigh !== expOut || cfgError !== expErr) begin
      errors++;
      $display("FAIL %s: out=%b high=%b err=%b expected out=%b high=%b err=%b (rule=%b inv=%b mask=%h data=%h)",
               tag, gateOut, outHigh, cfgError, expOut, expOut, expErr, r, inv, m, d);
    end
  endtask

  initial begin
    // reset-state: all inputs zero, select invalid
    apply(3'b000, 1'b0, '0, '0, "R7 idle");
    // R6 empty mask for each rule, plain and inverted
    apply(3'b001, 1'b0, '0, '1, "R6 and-empty");
    apply(3'b010, 1'b0, '0, '1, "R6 or-empty");
    apply(3'b100, 1'b0, '0, '1, "R6 xor-empty");
    apply(3'b001, 1'b1, '0, '1, "R6 nand-empty");
    apply(3'b100, 1'b1, '0, '0, "R4 xnor-zero-high");
    // R1 AND
    apply(3'b001, 1'b0, 8'h0F, 8'h0F, "R1 and-all");
    apply(3'b001, 1'b0, 8'h0F, 8'h07, "R1 and-miss");
    // R2 OR
    apply(3'b010, 1'b0, 8'hF0, 8'h10, "R2 or-one");
    apply(3'b010, 1'b0, 8'hF0, 8'h00, "R2 or-none");
    // R3 parity with 3 and 4 highs, full-adder sum
    apply(3'b100, 1'b0, 8'h07, 8'h07, "R3 xor-three");
    apply(3'b100, 1'b0, 8'hFF, 8'h0F, "R3 xor-four");
    apply(3'b100, 1'b0, 8'h07, 8'h05, "R3 fa-sum");
    // R4 inversions
    apply(3'b001, 1'b1, 8'hFF, 8'hFF, "R4 nand");
    apply(3'b010, 1'b1, 8'hFF, 8'h00, "R4 nor");
    apply(3'b100, 1'b1, 8'h03, 8'h01, "R4 xnor");
    // R5 unjoined lines high under each rule
    apply(3'b001, 1'b0, 8'h01, 8'hFF, "R5 and-leak");
    apply(3'b010, 1'b0, 8'h01, 8'hFE, "R5 or-leak");
    apply(3'b100, 1'b0, 8'h03, 8'hFC, "R5 xor-leak");
    // R9 single line buffer and inverter
    apply(3'b010, 1'b0, 8'h20, 8'h20, "R9 buf-1");
    apply(3'b010, 1'b0, 8'h20, 8'h00, "R9 buf-0");
    apply(3'b010, 1'b1, 8'h20, 8'h20, "R9 inv-1");
    apply(3'b010, 1'b1, 8'h20, 8'h00, "R9 inv-0");
    // R7 invalid selects with invert set
    apply(3'b000, 1'b1, 8'hFF, 8'hFF, "R7 zero-hot");
    apply(3'b011, 1'b1, 8'hFF, 8'h00, "R7 multi-hot");
    apply(3'b111, 1'b0, 8'hFF, 8'hFF, "R7 all-hot");
    // R8 and R10 across random patterns over the full default width
    for (int k = 0; k < 400; k++) begin
      apply(3'($urandom), 1'($urandom), 8'($urandom), 8'($urandom), "R8 R10 random");
    end
    finished = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !finished; c++) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule